// File: doc/BRIEF.md
# Register Rename Unit

This block sits at the rename stage of an out-of-order core and handles one instruction per cycle. Each instruction carries an opcode, two source operand slots and an optional architectural destination. A source slot holds either an architectural register index or an immediate. Register sources are looked up in a map table that turns each architectural register into the physical register holding its newest value. Immediates pass through unchanged.

When the instruction writes a register, the block takes the oldest entry of a free-list FIFO, gives it to the destination, and points the map table at it. Any later reader of that architectural register then gets the new name. True read-after-write links are kept. Write-after-write and write-after-read conflicts go away, because every write lands in a physical register that no one else is using.

The rename result is combinational in the cycle the instruction is presented, and the table and free list update on the following clock edge. If a destination is needed and the free list is empty, the block stalls. A flush puts the whole mapping back to its reset image. A probe port lets a neighbour read any map entry.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register ri maps to physical register pi for every i below NUM_ARCH (default: r0→p0, r1→p1, r2→p2, r3→p3). The free list holds p4 through p7, oldest first.
- R2: Register sources are translated through the mapping in force before the current instruction. An instruction that both reads and writes r1 sees r1's old physical name on its source.
- R3: A renamed instruction with a destination receives the head of the free list on out_dst_phys, and that number differs from every current mapping. From the next cycle the probe port and all later sources see the new name for that architectural register.
- R4: Free registers are handed out in FIFO order. From reset, four consecutive writers receive p4, p5, p6 and p7 in that order.
- R5: When the immediate flag of a source slot is set, that slot's full OPND_W-bit value appears unchanged on the matching output, and the output flag is also set.
- R6: When in_valid and in_has_dst are high and the free list is empty, stall is high and out_valid is low. The map table and the free list are left unchanged.
- R7: An instruction without a destination still has its register sources translated. It does not stall and takes no free register, so the next writer gets the same register it would otherwise have received.
- R8: A flush returns the map table and the free list to the R1 image on the next clock edge. An instruction presented in the flush cycle is not renamed: out_valid is low and nothing is allocated.
- R9: out_valid equals in_valid when the block is neither stalling nor flushing, and out_op is in_op unchanged. With in_valid low, no register is allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Restore reset mapping and free list |
| in_valid | input | 1 | Instruction present |
| in_op | input | OPW | Opcode |
| in_src1 | input | OPND_W | Source 1: architectural index (low bits) or immediate |
| in_src1_imm | input | 1 | Source 1 is an immediate |
| in_src2 | input | OPND_W | Source 2: architectural index (low bits) or immediate |
| in_src2_imm | input | 1 | Source 2 is an immediate |
| in_has_dst | input | 1 | Instruction writes a register |
| in_dst | input | clog2(NUM_ARCH) | Architectural destination |
| probe_arch | input | clog2(NUM_ARCH) | Map entry to read |
| probe_phys | output | clog2(NUM_PHYS) | Current mapping of probe_arch |
| stall | output | 1 | No free register for this instruction |
| out_valid | output | 1 | Renamed instruction valid |
| out_op | output | OPW | Opcode, passed through |
| out_src1 | output | OPND_W | Physical source 1 (zero-extended) or immediate |
| out_src1_imm | output | 1 | Source 1 is an immediate |
| out_src2 | output | OPND_W | Physical source 2 (zero-extended) or immediate |
| out_src2_imm | output | 1 | Source 2 is an immediate |
| out_has_dst | output | 1 | Renamed instruction writes a register |
| out_dst_phys | output | clog2(NUM_PHYS) | Newly allocated physical destination |

## Verification
On every cycle, the assertions check the following:
- A stall blocks both output and allocation.
- Every renamed write is backed by a non-empty free list and pops it.
- Destination-less instructions never pop.
- A flush suppresses the output and refills the list.
- Successive pops advance the head by one physical number.
- A fresh destination never equals the physical name read on source 1.

Only the bench's scenarios can show the following:
- The exact physical numbers of the four-instruction example.
- The map contents after each step.
- The old-name read on a self-overwriting instruction.
- That a later reader sees the new name.
- That allocation order resumes correctly after a flush.

// File: rtl/rename_pkg.sv
package rename_pkg;

  // Physical register an architectural register points at out of reset.
  function automatic int home_phys(input int areg);
    return areg;
  endfunction

  // Physical register held in free-list slot 'slot' out of reset.
  function automatic int seed_phys(input int narch, input int slot);
    return narch + slot;
  endfunction

  // Circular pointer advance for a FIFO of 'depth' slots.
  function automatic int wrap_inc(input int ptr, input int depth);
    return (ptr + 1 >= depth) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/rename_map_table.sv
module rename_map_table #(
  parameter int NUM_ARCH = 4,
  parameter int NUM_PHYS = 8,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [AW-1:0] rd1_arch,
  output logic [PW-1:0] rd1_phys,
  input  logic [AW-1:0] rd2_arch,
  output logic [PW-1:0] rd2_phys,
  input  logic [AW-1:0] rd3_arch,
  output logic [PW-1:0] rd3_phys,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_arch,
  input  logic [PW-1:0] wr_phys
);
  import rename_pkg::*;

  logic [PW-1:0] map_q [NUM_ARCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < NUM_ARCH; a++) map_q[a] <= PW'(home_phys(a));
    end else if (flush) begin
      for (int a = 0; a < NUM_ARCH; a++) map_q[a] <= PW'(home_phys(a));
    end else if (wr_en) begin
      map_q[wr_arch] <= wr_phys;
    end
  end

  // Reads see the table before this cycle's write lands.
  assign rd1_phys = map_q[rd1_arch];
  assign rd2_phys = map_q[rd2_arch];
  assign rd3_phys = map_q[rd3_arch];

endmodule

// File: rtl/rename_free_list.sv
module rename_free_list #(
  parameter int NUM_ARCH = 4,
  parameter int NUM_PHYS = 8,
  localparam int PW    = $clog2(NUM_PHYS),
  localparam int DEPTH = NUM_PHYS - NUM_ARCH,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             pop,
  output logic             empty,
  output logic [PW-1:0]    head,
  output logic [CNT_W-1:0] count
);
  import rename_pkg::*;

  logic [PW-1:0]    slot_q [DEPTH];
  logic [PTR_W-1:0] rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < DEPTH; s++) slot_q[s] <= PW'(seed_phys(NUM_ARCH, s));
      rd_ptr_q <= '0;
      cnt_q    <= CNT_W'(DEPTH);
    end else if (flush) begin
      for (int s = 0; s < DEPTH; s++) slot_q[s] <= PW'(seed_phys(NUM_ARCH, s));
      rd_ptr_q <= '0;
      cnt_q    <= CNT_W'(DEPTH);
    end else if (pop && cnt_q != '0) begin
      rd_ptr_q <= PTR_W'(wrap_inc(int'(rd_ptr_q), DEPTH));
      cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign empty = (cnt_q == '0);
  assign head  = slot_q[rd_ptr_q];
  assign count = cnt_q;

endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
  parameter int NUM_ARCH = 4,
  parameter int NUM_PHYS = 8,
  parameter int OPW      = 4,
  parameter int OPND_W   = 8,
  localparam int AW    = $clog2(NUM_ARCH),
  localparam int PW    = $clog2(NUM_PHYS),
  localparam int DEPTH = NUM_PHYS - NUM_ARCH,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  input  logic [OPW-1:0]    in_op,
  input  logic [OPND_W-1:0] in_src1,
  input  logic              in_src1_imm,
  input  logic [OPND_W-1:0] in_src2,
  input  logic              in_src2_imm,
  input  logic              in_has_dst,
  input  logic [AW-1:0]     in_dst,
  input  logic [AW-1:0]     probe_arch,
  output logic [PW-1:0]     probe_phys,
  output logic              stall,
  output logic              out_valid,
  output logic [OPW-1:0]    out_op,
  output logic [OPND_W-1:0] out_src1,
  output logic              out_src1_imm,
  output logic [OPND_W-1:0] out_src2,
  output logic              out_src2_imm,
  output logic              out_has_dst,
  output logic [PW-1:0]     out_dst_phys
);

  // Named internal events for the checker.
  logic             fl_empty;
  logic             fl_pop;
  logic [PW-1:0]    fl_head;
  logic [CNT_W-1:0] fl_count;
  logic             map_we;
  logic             rename_go;
  logic [PW-1:0]    src1_phys;
  logic [PW-1:0]    src2_phys;

  assign stall     = in_valid && in_has_dst && fl_empty && !flush;
  assign rename_go = in_valid && !flush && !stall;
  assign fl_pop    = rename_go && in_has_dst;
  assign map_we    = fl_pop;

  rename_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) i_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .rd1_arch (in_src1[AW-1:0]),
    .rd1_phys (src1_phys),
    .rd2_arch (in_src2[AW-1:0]),
    .rd2_phys (src2_phys),
    .rd3_arch (probe_arch),
    .rd3_phys (probe_phys),
    .wr_en    (map_we),
    .wr_arch  (in_dst),
    .wr_phys  (fl_head)
  );

  rename_free_list #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) i_free (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .pop   (fl_pop),
    .empty (fl_empty),
    .head  (fl_head),
    .count (fl_count)
  );

  assign out_valid    = rename_go;
  assign out_op       = in_op;
  assign out_src1     = in_src1_imm ? in_src1 : OPND_W'(src1_phys);
  assign out_src1_imm = in_src1_imm;
  assign out_src2     = in_src2_imm ? in_src2 : OPND_W'(src2_phys);
  assign out_src2_imm = in_src2_imm;
  assign out_has_dst  = in_has_dst;
  assign out_dst_phys = fl_head;

endmodule

// File: rtl/rename_unit_checker.sv
module rename_unit_checker #(
  parameter int NUM_ARCH = 4,
  parameter int NUM_PHYS = 8,
  parameter int OPND_W   = 8,
  localparam int PW    = $clog2(NUM_PHYS),
  localparam int DEPTH = NUM_PHYS - NUM_ARCH,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              stall,
  input logic              out_valid,
  input logic              out_has_dst,
  input logic [OPND_W-1:0] out_src1,
  input logic              out_src1_imm,
  input logic [PW-1:0]     out_dst_phys,
  input logic              fl_pop,
  input logic              fl_empty,
  input logic [PW-1:0]     fl_head,
  input logic [CNT_W-1:0]  fl_count
);

  a_r6_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!out_valid && !fl_pop));

  a_r6_stall_keeps_list: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !flush) |=> $stable(fl_count));

  a_r3_write_pops: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_has_dst) |-> (fl_pop && !fl_empty));

  a_r3_fresh_name: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_has_dst && !out_src1_imm) |-> (out_src1 != OPND_W'(out_dst_phys)));

  a_r7_no_dst_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_has_dst) |-> !fl_pop);

  a_r4_fifo_order: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_pop && !flush && fl_count > CNT_W'(1)) |=> (fl_head == PW'($past(fl_head) + 1'b1)));

  a_r8_flush_refill: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fl_count == CNT_W'(DEPTH)));

  a_r8_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!out_valid && !fl_pop));

endmodule

bind rename_unit rename_unit_checker #(
  .NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .OPND_W(OPND_W)
) i_rename_unit_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .flush        (flush),
  .stall        (stall),
  .out_valid    (out_valid),
  .out_has_dst  (out_has_dst),
  .out_src1     (out_src1),
  .out_src1_imm (out_src1_imm),
  .out_dst_phys (out_dst_phys),
  .fl_pop       (fl_pop),
  .fl_empty     (fl_empty),
  .fl_head      (fl_head),
  .fl_count     (fl_count)
);

// File: tb/test_rename_unit.sv
`timescale 1ns/1ps
module test_rename_unit;

  localparam int NUM_ARCH = 4;
  localparam int NUM_PHYS = 8;
  localparam int OPW      = 4;
  localparam int OPND_W   = 8;
  localparam int AW       = $clog2(NUM_ARCH);
  localparam int PW       = $clog2(NUM_PHYS);
  localparam int WD_LIMIT = 5000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              flush;
  logic              in_valid;
  logic [OPW-1:0]    in_op;
  logic [OPND_W-1:0] in_src1;
  logic              in_src1_imm;
  logic [OPND_W-1:0] in_src2;
  logic              in_src2_imm;
  logic              in_has_dst;
  logic [AW-1:0]     in_dst;
  logic [AW-1:0]     probe_arch;
  logic [PW-1:0]     probe_phys;
  logic              stall;
  logic              out_valid;
  logic [OPW-1:0]    out_op;
  logic [OPND_W-1:0] out_src1;
  logic              out_src1_imm;
  logic [OPND_W-1:0] out_src2;
  logic              out_src2_imm;
  logic              out_has_dst;
  logic [PW-1:0]     out_dst_phys;

  always #10 clk = ~clk;

  rename_unit #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .OPW(OPW), .OPND_W(OPND_W)) i_rename_unit (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_op(in_op),
    .in_src1(in_src1), .in_src1_imm(in_src1_imm), .in_src2(in_src2), .in_src2_imm(in_src2_imm),
    .in_has_dst(in_has_dst), .in_dst(in_dst), .probe_arch(probe_arch), .probe_phys(probe_phys),
    .stall(stall), .out_valid(out_valid), .out_op(out_op), .out_src1(out_src1),
    .out_src1_imm(out_src1_imm), .out_src2(out_src2), .out_src2_imm(out_src2_imm),
    .out_has_dst(out_has_dst), .out_dst_phys(out_dst_phys)
  );

  typedef struct packed {
    logic [3:0] op;
    logic [7:0] s1;  logic s1i;
    logic [7:0] s2;  logic s2i;
    logic [1:0] dst;
    logic [7:0] e1;  logic [7:0] e2;  logic [2:0] ed;
    logic [2:0] m1;  logic [2:0] m2;  logic [2:0] m3;
  } vec_t;

  // add r2,r3->r1 ; sub r2,r1->r3 ; mul r2,r3->r3 ; div r1,#4->r1
  localparam vec_t TBL [4] = '{
    '{4'd1, 8'd2, 1'b0, 8'd3, 1'b0, 2'd1, 8'd2, 8'd3, 3'd4, 3'd4, 3'd2, 3'd3},
    '{4'd2, 8'd2, 1'b0, 8'd1, 1'b0, 2'd3, 8'd2, 8'd4, 3'd5, 3'd4, 3'd2, 3'd5},
    '{4'd3, 8'd2, 1'b0, 8'd3, 1'b0, 2'd3, 8'd2, 8'd5, 3'd6, 3'd4, 3'd2, 3'd6},
    '{4'd4, 8'd1, 1'b0, 8'd4, 1'b1, 2'd1, 8'd4, 8'd4, 3'd7, 3'd7, 3'd2, 3'd6}
  };

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input bit v, input int op, input int s1, input bit s1i,
                       input int s2, input bit s2i, input bit hd, input int d);
    in_valid = v; in_op = OPW'(op);
    in_src1 = OPND_W'(s1); in_src1_imm = s1i;
    in_src2 = OPND_W'(s2); in_src2_imm = s2i;
    in_has_dst = hd; in_dst = AW'(d);
  endtask

  task automatic chk_map(input string req, input int m1, input int m2, input int m3);
    probe_arch = 2'd0; #1; chk({req, " map r0"}, int'(probe_phys), 0);
    probe_arch = 2'd1; #1; chk({req, " map r1"}, int'(probe_phys), m1);
    probe_arch = 2'd2; #1; chk({req, " map r2"}, int'(probe_phys), m2);
    probe_arch = 2'd3; #1; chk({req, " map r3"}, int'(probe_phys), m3);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WD_LIMIT);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; probe_arch = '0;
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R9 reset out_valid", int'(out_valid), 0);
    chk("R9 reset stall", int'(stall), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_map("R1 reset", 1, 2, 3);

    // Table-driven replay of the four-instruction example (R2 R3 R4 R5).
    for (int k = 0; k < 4; k++) begin
      drive(1, TBL[k].op, TBL[k].s1, TBL[k].s1i, TBL[k].s2, TBL[k].s2i, 1, TBL[k].dst);
      #2;
      chk("R9 out_valid", int'(out_valid), 1);
      chk("R9 out_op", int'(out_op), int'(TBL[k].op));
      chk("R2 src1", int'(out_src1), int'(TBL[k].e1));
      chk("R5 src2", int'(out_src2), int'(TBL[k].e2));
      chk("R5 src2 flag", int'(out_src2_imm), int'(TBL[k].s2i));
      chk("R4 dst order", int'(out_dst_phys), int'(TBL[k].ed));
      step();
      in_valid = 1'b0;
      chk_map("R3 after step", int'(TBL[k].m1), int'(TBL[k].m2), int'(TBL[k].m3));
    end

    // R6: free list empty, writer stalls and changes nothing.
    drive(1, 5, 1, 0, 3, 0, 1, 2);
    #2;
    chk("R6 stall", int'(stall), 1);
    chk("R6 out_valid", int'(out_valid), 0);
    step();
    in_valid = 1'b0;
    chk_map("R6 map held", 7, 2, 6);

    // R7: store-like instruction goes through while empty.
    drive(1, 6, 1, 0, 3, 0, 0, 0);
    #2;
    chk("R7 no stall", int'(stall), 0);
    chk("R7 out_valid", int'(out_valid), 1);
    chk("R7 src1", int'(out_src1), 7);
    chk("R7 src2", int'(out_src2), 6);
    step();

    // R8: flush with a writer presented; writer is dropped.
    flush = 1'b1;
    drive(1, 1, 1, 0, 2, 0, 1, 3);
    #2;
    chk("R8 out_valid in flush", int'(out_valid), 0);
    step();
    flush = 1'b0;
    in_valid = 1'b0;
    chk_map("R8 restored", 1, 2, 3);

    // R7: no-dst instruction takes no register; next writer gets p4.
    drive(1, 6, 1, 0, 2, 0, 0, 0);
    step();
    drive(1, 1, 1, 0, 2, 0, 1, 3);
    #2;
    chk("R7 next writer", int'(out_dst_phys), 4);
    chk("R8 first after flush", int'(out_src1), 1);
    step();

    // R2: read and write r1 in one instruction.
    drive(1, 2, 1, 0, 1, 0, 1, 1);
    #2;
    chk("R2 self src1", int'(out_src1), 1);
    chk("R2 self src2", int'(out_src2), 1);
    chk("R4 dst after p4", int'(out_dst_phys), 5);
    step();

    // R3 next reader sees new name; R5 immediate passthrough; R9 op passthrough.
    drive(1, 15, 8'hA5, 1, 1, 0, 0, 0);
    #2;
    chk("R5 imm value", int'(out_src1), 8'hA5);
    chk("R5 imm flag", int'(out_src1_imm), 1);
    chk("R3 new name seen", int'(out_src2), 5);
    chk("R9 op pass", int'(out_op), 15);
    step();

    // R9: invalid writer allocates nothing.
    drive(0, 1, 1, 0, 2, 0, 1, 2);
    #2;
    chk("R9 idle out_valid", int'(out_valid), 0);
    step();
    drive(1, 1, 1, 0, 2, 0, 1, 2);
    #2;
    chk("R9 no alloc when idle", int'(out_dst_phys), 6);
    step();
    in_valid = 1'b0;
    chk_map("R3 final", 5, 6, 4);

    finish_run();
  end

endmodule